// File: doc/BRIEF.md
# Nibble-Serial Bus CRC Accumulator

This block keeps a 16-bit signature of the data a processor pulls over a 4-bit bus. Each cycle a delivered nibble may be folded into the signature with a 16-entry lookup keyed on the current top nibble. One nibble is folded per clock, so a multi-nibble read shows up as a burst of consecutive strobes.

A small register window exposes the signature as four nibble slots. Slot 0 holds bits 3:0 and slot 3 holds bits 15:12. Software can read or overwrite any single slot. Debug (peek) reads and all writes leave the signature alone. A read of slots 0, 1 or 2 is not folded back in, while a read of slot 3 is.

An optional companion accumulator of the same form steps with a zero input on every real read. It models a second chip that sees only the bus timing.

Top module: `nibcrc_accum`

## Requirements
- R1: On a folded nibble n, the signature becomes ({crc[11:0], n}) XOR T[crc[15:12]]. T, indexed 0 to 15, is 0000, 6801, D002, B803, C805, A004, 1807, 7006, F80B, 900A, 2809, 4008, 300E, 580F, E00C, 880D (hex). For example, 0x1234 folded with 5 gives 0x4B44.
- R2: While `rst` is high at a clock edge, both the signature and the companion clear to 0 at that edge.
- R3: `reg_rdata` shows signature bits [4*reg_idx+3 : 4*reg_idx] combinationally.
- R4: A write (`reg_sel` and `reg_wr`) replaces only slot `reg_idx` with `reg_wdata`; the other 12 bits keep their value.
- R5: A strobe with `rd_peek` high changes neither the signature nor the companion. A write never folds anything.
- R6: A non-peek strobe with `reg_sel` high and `reg_wr` low is a read of the signature itself. For slots 0 to 2 the signature is unchanged. For slot 3 the signature is folded with its own bits 15:12.
- R7: A non-peek strobe with `reg_sel` low folds `rd_nib`. Strobes on consecutive cycles each fold one nibble, in order.
- R8: When a write and `rd_stb` occur in the same cycle, the write is applied and nothing is folded.
- R9: The companion folds a 0 nibble on every non-peek read strobe, including self-reads of any slot. Writes and peeks do not move it.
- R10: With no strobe and no write, the signature holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | A nibble is delivered to the processor this cycle |
| rd_peek | input | 1 | The delivery is a debug peek; blocks all folding |
| rd_nib | input | 4 | Delivered nibble for reads outside the signature window |
| reg_sel | input | 1 | The access targets the signature window |
| reg_wr | input | 1 | Window access is a write |
| reg_idx | input | 2 | Window slot, 0 = least significant nibble |
| reg_wdata | input | 4 | Nibble to write into the slot |
| reg_rdata | output | 4 | Current content of the selected slot |
| crc_out | output | 16 | Signature value |
| slave_crc_out | output | 16 | Companion signature value (0 when disabled) |

## Verification
A corrupted signature or a wrong exclusion decision appears on `crc_out` one clock after the offending strobe. Because every later fold mixes in the top nibble, the error then persists and spreads through subsequent values rather than washing out. The bench compares both outputs against a table model after every cycle of random nibble streams with random peeks. A single misfolded, skipped or extra update is therefore caught in the very next cycle. Slot write masking and self-read exclusion are checked slot by slot, both through `reg_rdata` and through the full output.

// File: rtl/nibcrc_pkg.sv
package nibcrc_pkg;

    localparam int NIB_W   = 4;
    localparam int CRC_W   = 16;
    localparam int NIB_CNT = CRC_W / NIB_W;
    localparam int IDX_W   = $clog2(NIB_CNT);
    localparam int TAB_N   = 1 << NIB_W;

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [CRC_W-1:0] crc_t;
    typedef logic [IDX_W-1:0] idx_t;

    // decoded per-cycle actions
    typedef struct packed {
        logic upd;
        nib_t upd_nib;
        logic wr;
        idx_t wr_idx;
        nib_t wr_nib;
        logic slv_step;
    } act_t;

    function automatic crc_t fold_tab(input nib_t k);
        crc_t v;
        case (k)
            4'h0: v = 16'h0000;
            4'h1: v = 16'h6801;
            4'h2: v = 16'hD002;
            4'h3: v = 16'hB803;
            4'h4: v = 16'hC805;
            4'h5: v = 16'hA004;
            4'h6: v = 16'h1807;
            4'h7: v = 16'h7006;
            4'h8: v = 16'hF80B;
            4'h9: v = 16'h900A;
            4'hA: v = 16'h2809;
            4'hB: v = 16'h4008;
            4'hC: v = 16'h300E;
            4'hD: v = 16'h580F;
            4'hE: v = 16'hE00C;
            default: v = 16'h880D;
        endcase
        return v;
    endfunction

    function automatic crc_t crc_fold(input crc_t c, input nib_t n);
        return {c[CRC_W-NIB_W-1:0], n} ^ fold_tab(c[CRC_W-1 -: NIB_W]);
    endfunction

    function automatic crc_t nib_mask(input idx_t i);
        return crc_t'({NIB_W{1'b1}}) << (int'(i) * NIB_W);
    endfunction

    function automatic nib_t nib_get(input crc_t c, input idx_t i);
        return nib_t'(c >> (int'(i) * NIB_W));
    endfunction

endpackage

// File: rtl/nibcrc_decode.sv
module nibcrc_decode
    import nibcrc_pkg::*;
(
    input  logic rd_stb,
    input  logic rd_peek,
    input  nib_t rd_nib,
    input  logic reg_sel,
    input  logic reg_wr,
    input  idx_t reg_idx,
    input  nib_t reg_wdata,
    input  crc_t cur_crc,
    output act_t act,
    output nib_t reg_rdata
);
    localparam idx_t TOP_IDX = idx_t'(NIB_CNT - 1);

    logic wr_hit, rd_real, self_rd;
    nib_t self_nib;

    always_comb begin
        self_nib = nib_get(cur_crc, reg_idx);
        wr_hit   = reg_sel & reg_wr;
        rd_real  = rd_stb & ~wr_hit & ~rd_peek;
        self_rd  = reg_sel & ~reg_wr;

        act          = '0;
        act.wr       = wr_hit;
        act.wr_idx   = reg_idx;
        act.wr_nib   = reg_wdata;
        act.upd_nib  = self_rd ? self_nib : rd_nib;
        act.upd      = rd_real & (~self_rd | (reg_idx == TOP_IDX));
        act.slv_step = rd_real;
        reg_rdata    = self_nib;
    end
endmodule

// File: rtl/nibcrc_reg.sv
module nibcrc_reg
    import nibcrc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  nib_t upd_nib,
    input  logic wr,
    input  idx_t wr_idx,
    input  nib_t wr_nib,
    output crc_t crc_q
);
    crc_t crc_nxt;

    always_comb begin
        crc_nxt = crc_q;
        if (wr)
            crc_nxt = (crc_q & ~nib_mask(wr_idx)) | (crc_t'(wr_nib) << (int'(wr_idx) * NIB_W));
        else if (upd)
            crc_nxt = crc_fold(crc_q, upd_nib);
    end

    always_ff @(posedge clk) begin
        if (rst) crc_q <= '0;
        else     crc_q <= crc_nxt;
    end

    AST_RST_CLEAR: assert property (@(posedge clk) rst |=> crc_q == '0); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!upd && !wr) |=> $stable(crc_q)); // R10
    AST_WR_KEEP_REST: assert property (@(posedge clk) disable iff (rst)
        wr |=> ((crc_q ^ $past(crc_q)) & ~nib_mask($past(wr_idx))) == '0); // R4
    AST_WR_SLOT_LOADED: assert property (@(posedge clk) disable iff (rst)
        wr |=> nib_get(crc_q, $past(wr_idx)) == $past(wr_nib)); // R4
endmodule

// File: rtl/nibcrc_accum.sv
module nibcrc_accum
    import nibcrc_pkg::*;
#(
    parameter bit HAS_SLAVE = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_stb,
    input  logic        rd_peek,
    input  logic [3:0]  rd_nib,
    input  logic        reg_sel,
    input  logic        reg_wr,
    input  logic [1:0]  reg_idx,
    input  logic [3:0]  reg_wdata,
    output logic [3:0]  reg_rdata,
    output logic [15:0] crc_out,
    output logic [15:0] slave_crc_out
);
    localparam idx_t TOP_IDX = idx_t'(NIB_CNT - 1);

    act_t act;
    crc_t mst_crc;

    nibcrc_decode u_dec (
        .rd_stb    (rd_stb),
        .rd_peek   (rd_peek),
        .rd_nib    (rd_nib),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .cur_crc   (mst_crc),
        .act       (act),
        .reg_rdata (reg_rdata)
    );

    nibcrc_reg u_mst (
        .clk     (clk),
        .rst     (rst),
        .upd     (act.upd),
        .upd_nib (act.upd_nib),
        .wr      (act.wr),
        .wr_idx  (act.wr_idx),
        .wr_nib  (act.wr_nib),
        .crc_q   (mst_crc)
    );

    generate
        if (HAS_SLAVE) begin : g_slave
            crc_t slv_crc;
            nibcrc_reg u_slv (
                .clk     (clk),
                .rst     (rst),
                .upd     (act.slv_step),
                .upd_nib ('0),
                .wr      (1'b0),
                .wr_idx  ('0),
                .wr_nib  ('0),
                .crc_q   (slv_crc)
            );
            assign slave_crc_out = slv_crc;
        end else begin : g_no_slave
            assign slave_crc_out = '0;
        end
    endgenerate

    assign crc_out = mst_crc;

    AST_PEEK_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && rd_peek && !(reg_sel && reg_wr)) |=> ($stable(crc_out) && $stable(slave_crc_out))); // R5
    AST_SELF_EXCL: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && reg_sel && !reg_wr && reg_idx != TOP_IDX) |=> $stable(crc_out)); // R6
    AST_WR_WINS: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && reg_wr) |-> !act.upd); // R8
    AST_SLAVE_IGNORES_WR: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && reg_wr) |=> $stable(slave_crc_out)); // R9
endmodule

// File: tb/nibcrc_accum_tb.sv
module nibcrc_accum_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        rd_stb, rd_peek, reg_sel, reg_wr;
    logic [3:0]  rd_nib, reg_wdata, reg_rdata;
    logic [1:0]  reg_idx;
    logic [15:0] crc_out, slave_crc_out;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] m_crc, m_slv;
    logic [15:0] tab [16] = '{16'h0000, 16'h6801, 16'hD002, 16'hB803, 16'hC805, 16'hA004,
                              16'h1807, 16'h7006, 16'hF80B, 16'h900A, 16'h2809, 16'h4008,
                              16'h300E, 16'h580F, 16'hE00C, 16'h880D};

    always #2 clk = ~clk;

    nibcrc_accum dut_i (
        .clk(clk), .rst(rst), .rd_stb(rd_stb), .rd_peek(rd_peek), .rd_nib(rd_nib),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .crc_out(crc_out), .slave_crc_out(slave_crc_out)
    );

    function automatic logic [15:0] ref_fold(input logic [15:0] c, input logic [3:0] n);
        return {c[11:0], n} ^ tab[c[15:12]];
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one bus cycle; the model follows the requirements
    task automatic cyc(input logic s, input logic p, input logic [3:0] n,
                       input logic sel, input logic w, input logic [1:0] i,
                       input logic [3:0] wd);
        logic [3:0] nib;
        @(negedge clk);
        rd_stb = s; rd_peek = p; rd_nib = n;
        reg_sel = sel; reg_wr = w; reg_idx = i; reg_wdata = wd;
        @(posedge clk);
        #1;
        if (sel && w) begin
            m_crc[i*4 +: 4] = wd;
        end else if (s && !p) begin
            nib = sel ? m_crc[i*4 +: 4] : n;
            if (!sel || i == 2'd3) m_crc = ref_fold(m_crc, nib);
            m_slv = ref_fold(m_slv, 4'h0);
        end
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic load(input logic [15:0] v);
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1, 1, 2'(k), v[k*4 +: 4]);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        m_crc = '0; m_slv = '0;
        chk("R2 crc after reset", crc_out, 16'h0000);
        chk("R2 slave after reset", slave_crc_out, 16'h0000);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_known();
        cyc(1, 0, 4'h1, 0, 0, 0, 0);
        chk("R1 fold 1 from zero", crc_out, 16'h0001);
        load(16'h1234);
        chk("R4 loaded value", crc_out, 16'h1234);
        cyc(1, 0, 4'h5, 0, 0, 0, 0);
        chk("R1 fold 5 into 1234", crc_out, 16'h4B44);
        chk("R1 model agrees", crc_out, m_crc);
    endtask

    task automatic t_stream();
        for (int k = 0; k < 300; k++) begin
            logic pk;
            pk = ($urandom % 4) == 0;
            cyc(1, pk, 4'($urandom), 0, 0, 0, 0);
            chk(pk ? "R5 peek stream" : "R7 burst fold", crc_out, m_crc);
            chk("R9 slave stream", slave_crc_out, m_slv);
        end
    endtask

    task automatic t_self();
        load(16'hA5C3);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            reg_sel = 1'b1; reg_wr = 1'b0; reg_idx = 2'(k); rd_stb = 1'b0;
            #1;
            chk("R3 slot readback", {12'h0, reg_rdata}, {12'h0, m_crc[k*4 +: 4]});
        end
        for (int k = 0; k < 3; k++) begin
            cyc(1, 0, 4'hF, 1, 0, 2'(k), 0);
            chk("R6 low slot self read", crc_out, 16'hA5C3);
            chk("R9 slave on self read", slave_crc_out, m_slv);
        end
        cyc(1, 0, 4'h0, 1, 0, 2'd3, 0);
        chk("R6 top slot self read folds", crc_out, ref_fold(16'hA5C3, 4'hA));
    endtask

    task automatic t_write();
        logic [15:0] base;
        load(16'h0000);
        base = m_crc;
        for (int k = 0; k < 4; k++) begin
            cyc(0, 0, 0, 1, 1, 2'(k), 4'(k + 9));
            base[k*4 +: 4] = 4'(k + 9);
            chk("R4 single slot write", crc_out, base);
        end
        chk("R9 slave untouched by writes", slave_crc_out, m_slv);
        cyc(1, 1, 4'h7, 0, 0, 0, 0);
        chk("R5 peek holds", crc_out, base);
        repeat (3) idle();
        chk("R10 idle hold", crc_out, base);
    endtask

    task automatic t_prio();
        load(16'h8F21);
        cyc(1, 0, 4'hE, 1, 1, 2'd2, 4'h4);
        chk("R8 write beats fold", crc_out, 16'h8421);
        chk("R8 slave no step", slave_crc_out, m_slv);
        cyc(1, 0, 4'hE, 0, 0, 0, 0);
        chk("R7 fold after write", crc_out, ref_fold(16'h8421, 4'hE));
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; rd_stb = 0; rd_peek = 0; rd_nib = 0;
        reg_sel = 0; reg_wr = 0; reg_idx = 0; reg_wdata = 0;
        m_crc = '0; m_slv = '0;
        t_reset();
        t_known();
        t_stream();
        t_self();
        t_write();
        t_prio();
        t_stream();
        t_reset();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule